// File: doc/BRIEF.md
# Exception Priority Masking Unit

This block holds the three masking controls that sit between a pending exception and its activation: a one-bit global mask, a base priority threshold and a one-bit fault mask. From them it forms an effective mask priority. It compares the priority of the pending exception with the lower of that mask priority and the priority the processor is running at, and raises a take signal when the exception may be activated.

Software changes the threshold through a write port that has two modes. A plain write stores any value. A raise-only write stores its value only when that tightens the masking. Separate set and clear strobes control the two mask bits. The write port and all four strobes depend on a privilege qualifier. An exception-return strobe clears the fault mask unless the return is from the non-maskable handler.

Masking never drops an exception. It only holds back activation, so the pending store outside the block keeps the exception. Arbitration among several pending exceptions is done elsewhere.

Top module: `prio_mask_unit`

## Requirements
- R1: After reset the global mask, the fault mask and the threshold are all zero, and `mask_prio_o` reads 2^PRIO_W (256 by default), which means no masking.
- R2: While the global mask is set, every exception of configurable kind is blocked, including priority 0. Hard fault and NMI can still be taken.
- R3: A non-zero threshold blocks configurable exceptions whose priority value is equal to or greater than the threshold. A threshold of zero masks nothing.
- R4: A raise-only write (`wr_max_i`=1) replaces the threshold only when its data is non-zero and the threshold is zero or greater than the data. In all other cases the threshold keeps its value. A plain write (`wr_max_i`=0) always stores its data.
- R5: While the fault mask is set, configurable exceptions and hard fault are blocked. NMI can still be taken.
- R6: An exception return with `ret_nmi_i`=0 clears the fault mask on the following edge, even when the core is unprivileged. A return with `ret_nmi_i`=1 leaves the fault mask unchanged.
- R7: When `priv_i`=0, threshold writes and the set and clear strobes of both masks have no effect.
- R8: Priorities are signed. `pend_kind_i` selects the priority: 0 or 3 means configurable and uses `pend_prio_i`, 1 means hard fault at -1, and 2 means NMI at -2. `take_o` is 1 only when that priority is strictly lower than both `run_prio_i` and `mask_prio_o`.
- R9: When a clear and a set of the same mask bit arrive in one cycle, the clear wins. A non-NMI exception return in the same cycle as a fault-mask set also leaves the fault mask cleared.
- R10: `mask_prio_o` is -1 when the fault mask is set. Otherwise it is 0 when the global mask is set. Otherwise it is the threshold when the threshold is non-zero, and 2^PRIO_W when it is zero.
- R11: `take_o` is 0 whenever `pend_valid_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 1 | Core is privileged this cycle |
| wr_en_i | input | 1 | Threshold write strobe |
| wr_max_i | input | 1 | 1: raise-only write, 0: plain write |
| wr_data_i | input | PRIO_W | Threshold write data |
| gm_set_i | input | 1 | Set the global mask |
| gm_clr_i | input | 1 | Clear the global mask |
| fm_set_i | input | 1 | Set the fault mask |
| fm_clr_i | input | 1 | Clear the fault mask |
| ret_i | input | 1 | Exception return strobe |
| ret_nmi_i | input | 1 | The return is from the NMI handler |
| pend_valid_i | input | 1 | A pending exception is offered |
| pend_kind_i | input | 2 | 0/3 configurable, 1 hard fault, 2 NMI |
| pend_prio_i | input | PRIO_W | Priority of a configurable exception |
| run_prio_i | input | PRIO_W+2 | Signed current running priority |
| take_o | output | 1 | Offered exception may be activated |
| mask_prio_o | output | PRIO_W+2 | Signed effective mask priority |
| gmask_o | output | 1 | Global mask state |
| fmask_o | output | 1 | Fault mask state |
| thresh_o | output | PRIO_W | Threshold state |

## Verification
Two updates of the fault mask can fall in the same cycle. One is a set or clear strobe from privileged code. The other is the automatic clear from an exception return. The bench drives a fault-mask set together with a non-NMI return, and separately a set together with a clear. In both cases it expects the mask to read clear after the edge and a hard fault to be taken in the next cycle. The same collision is then repeated with an NMI return, where the set must survive. Raise-only writes are also applied in the same cycles as configurable exceptions are offered, to confirm that the take decision uses the threshold from before the write.

// File: rtl/prio_mask_unit.sv
module prio_mask_unit #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv_i,
  input  logic              wr_en_i,
  input  logic              wr_max_i,
  input  logic [PRIO_W-1:0] wr_data_i,
  input  logic              gm_set_i,
  input  logic              gm_clr_i,
  input  logic              fm_set_i,
  input  logic              fm_clr_i,
  input  logic              ret_i,
  input  logic              ret_nmi_i,
  input  logic              pend_valid_i,
  input  logic [1:0]        pend_kind_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic [PRIO_W+1:0] run_prio_i,
  output logic              take_o,
  output logic [PRIO_W+1:0] mask_prio_o,
  output logic              gmask_o,
  output logic              fmask_o,
  output logic [PRIO_W-1:0] thresh_o
);

  localparam int EW = PRIO_W + 2;
  localparam logic signed [EW-1:0] P_NONE = EW'(1) <<< PRIO_W;
  localparam logic signed [EW-1:0] P_HF   = -EW'(1);
  localparam logic signed [EW-1:0] P_NMI  = -EW'(2);
  localparam logic [1:0] K_HF  = 2'd1;
  localparam logic [1:0] K_NMI = 2'd2;

  logic              gm_q, fm_q;
  logic [PRIO_W-1:0] bp_q;
  logic              raise_ok, bp_we;
  logic signed [EW-1:0] mask_p, pend_p, run_p, floor_p;

  assign raise_ok = (wr_data_i != '0) && ((bp_q == '0) || (wr_data_i < bp_q));
  assign bp_we    = priv_i && wr_en_i && (!wr_max_i || raise_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gm_q <= 1'b0;
      fm_q <= 1'b0;
      bp_q <= '0;
    end else begin
      if (priv_i && gm_clr_i)      gm_q <= 1'b0;
      else if (priv_i && gm_set_i) gm_q <= 1'b1;

      if (ret_i && !ret_nmi_i)     fm_q <= 1'b0;
      else if (priv_i && fm_clr_i) fm_q <= 1'b0;
      else if (priv_i && fm_set_i) fm_q <= 1'b1;

      if (bp_we) bp_q <= wr_data_i;
    end
  end

  always_comb begin
    if (fm_q)            mask_p = P_HF;
    else if (gm_q)       mask_p = '0;
    else if (bp_q != '0) mask_p = EW'(bp_q);
    else                 mask_p = P_NONE;
  end

  always_comb begin
    case (pend_kind_i)
      K_NMI:   pend_p = P_NMI;
      K_HF:    pend_p = P_HF;
      default: pend_p = EW'(pend_prio_i);
    endcase
  end

  assign run_p   = $signed(run_prio_i);
  assign floor_p = (run_p < mask_p) ? run_p : mask_p;
  assign take_o  = pend_valid_i && (pend_p < floor_p);

  assign mask_prio_o = mask_p;
  assign gmask_o     = gm_q;
  assign fmask_o     = fm_q;
  assign thresh_o    = bp_q;

  AST_UNPRIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_i && !ret_i) |=> ($stable(gm_q) && $stable(fm_q) && $stable(bp_q))); // R7
  AST_FM_RET_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !ret_nmi_i) |=> !fmask_o); // R6
  AST_FM_NMI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && ret_nmi_i && !(priv_i && (fm_set_i || fm_clr_i))) |=> $stable(fmask_o)); // R6
  AST_MAX_NO_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i && wr_en_i && wr_max_i && (thresh_o != '0) && (wr_data_i >= thresh_o)) |=> $stable(thresh_o)); // R4
  AST_NMI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid_i && pend_kind_i == K_NMI && $signed(run_prio_i) > P_NMI) |-> take_o); // R5
  AST_FM_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (fmask_o && pend_kind_i != K_NMI) |-> !take_o); // R5
  AST_GM_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask_o && (pend_kind_i == 2'd0 || pend_kind_i == 2'd3)) |-> !take_o); // R2
  AST_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid_i |-> !take_o); // R11

endmodule

// File: tb/prio_mask_unit_tb_top.sv
module prio_mask_unit_tb_top;
  localparam int PW = 8;
  localparam int EW = PW + 2;
  localparam int NONE = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic priv, we, wm, gs, gc, fs, fc, er, en, pv;
  logic [PW-1:0] wd, pp;
  logic [1:0] pk;
  logic [EW-1:0] rp;
  logic take;
  logic [EW-1:0] mprio;
  logic gmo, fmo;
  logic [PW-1:0] tho;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  prio_mask_unit #(.PRIO_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .wr_en_i(we), .wr_max_i(wm), .wr_data_i(wd),
    .gm_set_i(gs), .gm_clr_i(gc), .fm_set_i(fs), .fm_clr_i(fc), .ret_i(er), .ret_nmi_i(en),
    .pend_valid_i(pv), .pend_kind_i(pk), .pend_prio_i(pp), .run_prio_i(rp),
    .take_o(take), .mask_prio_o(mprio), .gmask_o(gmo), .fmask_o(fmo), .thresh_o(tho));

  always #4 clk = ~clk;

  typedef struct {
    bit        tk;
    bit        g;
    bit        f;
    int        b;
    int        mp;
    string     tag;
  } exp_t;
  exp_t q[$];

  bit m_g = 0, m_f = 0;
  int m_b = 0;

  function automatic int model_mask();
    if (m_f) return -1;
    if (m_g) return 0;
    if (m_b != 0) return m_b;
    return NONE;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit ipv, int ipk, int ipp, int irp, bit ipr,
                      bit iwe, bit iwm, int iwd, bit igs, bit igc, bit ifs, bit ifc,
                      bit ier, bit ien, string tag);
    exp_t e;
    int pprio, fl, mk;
    @(negedge clk);
    pv = ipv; pk = 2'(ipk); pp = PW'(ipp); rp = EW'(irp); priv = ipr;
    we = iwe; wm = iwm; wd = PW'(iwd); gs = igs; gc = igc; fs = ifs; fc = ifc;
    er = ier; en = ien;
    mk = model_mask();
    pprio = (ipk == 2) ? -2 : (ipk == 1) ? -1 : ipp;
    fl = (irp < mk) ? irp : mk;
    e.tk = ipv && (pprio < fl);
    if (ipr && iwe) begin
      if (!iwm) m_b = iwd;
      else if (iwd != 0 && (m_b == 0 || iwd < m_b)) m_b = iwd;
    end
    if (ipr && igc) m_g = 0; else if (ipr && igs) m_g = 1;
    if (ier && !ien) m_f = 0; else if (ipr && ifc) m_f = 0; else if (ipr && ifs) m_f = 1;
    e.g = m_g; e.f = m_f; e.b = m_b; e.mp = model_mask(); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle_pend(int k, int p, string tag);
    step(1, k, p, NONE, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() != 0) begin
        e = q.pop_front();
        check(take == e.tk, e.tag, "take", int'(take), int'(e.tk));
        @(posedge clk);
        #1;
        check(gmo == e.g && fmo == e.f && int'(tho) == e.b, e.tag, "state g/f/b",
              int'({gmo, fmo, tho}), int'({e.g, e.f, PW'(e.b)}));
        check($signed(mprio) == e.mp, e.tag, "mask_prio", int'($signed(mprio)), e.mp);
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : driver
    {priv, we, wm, gs, gc, fs, fc, er, en, pv} = '0;
    wd = '0; pp = '0; pk = '0; rp = EW'(NONE);
    repeat (3) @(posedge clk);
    #1;
    check(gmo == 0 && fmo == 0 && tho == 0, "R1", "reset state", int'({gmo, fmo, tho}), 0);
    check($signed(mprio) == NONE, "R1", "reset mask_prio", int'($signed(mprio)), NONE);
    @(negedge clk); rst_n = 1'b1;

    // R8 strict comparison against running priority
    step(1, 0, 5, NONE, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 0, 5, 5,    1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 0, 5, 6,    1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 1, 0, -1,   1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 3, 9, 10,   1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R11
    step(0, 2, 0, NONE, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    // R2 global mask
    step(1, 0, 0, NONE, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R2");
    idle_pend(0, 0, "R2");
    idle_pend(1, 0, "R2");
    idle_pend(2, 0, "R2");
    // R7 unprivileged strobes and writes
    step(1, 0, 0, NONE, 0, 1, 0, 8'h33, 0, 1, 1, 0, 0, 0, "R7");
    idle_pend(0, 0, "R7");
    step(1, 0, 0, NONE, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R2");
    // R3 threshold
    step(1, 0, 8'h40, NONE, 1, 1, 0, 8'h40, 0, 0, 0, 0, 0, 0, "R3");
    idle_pend(0, 8'h40, "R3");
    idle_pend(0, 8'h3F, "R3");
    idle_pend(0, 8'h80, "R3");
    step(1, 0, 8'h80, NONE, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    idle_pend(0, 8'h80, "R3");
    // R4 raise-only writes
    step(1, 0, 8'h70, NONE, 1, 1, 1, 8'h60, 0, 0, 0, 0, 0, 0, "R4");
    step(1, 0, 8'h70, NONE, 1, 1, 1, 8'h80, 0, 0, 0, 0, 0, 0, "R4");
    step(1, 0, 8'h5F, NONE, 1, 1, 1, 8'h60, 0, 0, 0, 0, 0, 0, "R4");
    step(1, 0, 8'h30, NONE, 1, 1, 1, 8'h00, 0, 0, 0, 0, 0, 0, "R4");
    step(1, 0, 8'h30, NONE, 1, 1, 1, 8'h20, 0, 0, 0, 0, 0, 0, "R4");
    idle_pend(0, 8'h30, "R4");
    step(1, 0, 8'h30, NONE, 1, 1, 0, 8'h90, 0, 0, 0, 0, 0, 0, "R4");
    idle_pend(0, 8'h30, "R4");
    // R5 fault mask and R10 precedence
    step(1, 1, 0, NONE, 1, 0, 0, 0, 1, 0, 1, 0, 0, 0, "R10");
    idle_pend(1, 0, "R5");
    idle_pend(2, 0, "R5");
    idle_pend(0, 0, "R5");
    // R6 returns
    step(1, 1, 0, NONE, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R6");
    step(1, 1, 0, NONE, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
    idle_pend(1, 0, "R10");
    step(1, 0, 8'h10, NONE, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R10");
    idle_pend(0, 8'h10, "R10");
    // R9 collisions
    step(1, 1, 0, NONE, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R9");
    idle_pend(1, 0, "R9");
    step(1, 1, 0, NONE, 1, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R9");
    idle_pend(1, 0, "R9");
    step(1, 1, 0, NONE, 1, 0, 0, 0, 0, 0, 1, 0, 1, 1, "R9");
    idle_pend(1, 0, "R9");
    step(1, 0, 0, NONE, 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R9");
    idle_pend(0, 0, "R9");

    step(0, 0, 0, NONE, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    repeat (3) @(posedge clk);
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule